// File: doc/BRIEF.md
# Fixed-Point Scale Step Generator

The block turns a source size, a destination size and a pre-decimation code into the fixed-point increment one resampling axis needs. It then walks that increment across the output samples. Unity scale is `2^21` (0x200000). The master step is the effective source size times `2^21`, divided by the destination size and always rounded up. The effective source size is the source size after an optional decimation by 2 or 4. The quotient comes from a sequential restoring divider that yields one bit per cycle. The block also derives several secondary steps from the master step by fixed shifts. A parameter chooses the horizontal or the vertical set.

Once the step is loaded, each advance strobe adds it to an accumulator. The integer part is the source sample to read, and the fraction is the interpolation phase. The top four fraction bits select one of 16 filter phases. One instance serves one axis of one plane, so luma and chroma each get their own instance.

Configuration enters through a valid/ready pair. `cfg_ready` is low from the accepted beat until the new step is loaded. A source holding `cfg_valid` high during that time simply waits, and its values are not taken. The advance strobe and the status outputs are plain pins.

Top module: `scale_step_gen`

## Requirements
- R1: A configuration is taken only on a cycle with `cfg_valid` and `cfg_ready` both high. `cfg_ready` goes low on the cycle after a legal configuration is taken and stays low until the step is loaded. Beats offered while it is low have no effect.
- R2: `step_master` equals ceil(E·2^21 / D). D is the destination size and E is the source size shifted right by 0, 1 or 2 for division codes 00, 01 and 10.
- R3: Division code 11, a zero source size or a zero destination size makes the configuration illegal. An illegal configuration sets `cfg_error` and leaves `step_master`, the derived steps and `step_valid` unchanged. The next legal configuration clears `cfg_error`.
- R4: With `VERTICAL`=0, `step_luma` and `step_chroma` equal `step_master >> 2` and `step_extra` equals `step_master >> 1`.
- R5: With `VERTICAL`=1, `step_luma` equals `step_master >> 2` and `step_extra` equals `step_luma + 0x514`. `step_chroma` equals `step_master >> 2` for division code 00 and `step_master >> 3` for any other code.
- R6: `step_valid` falls on the cycle after a legal configuration is taken. It rises when the new step is loaded, and at that moment `src_index` and `phase` are zero.
- R7: Each cycle with `adv` high, `step_valid` high and `walk_done` low adds `step_master` to the position. `src_index` is position bits above bit 20, `phase` is bits 20..0, and `phase_sel` is bits 20..17.
- R8: `walk_done` goes high once the number of advances equals the destination size. Further advances then leave `src_index` and `phase` unchanged.
- R9: An advance while the step is being computed, or on the cycle the step is loaded, is ignored. The load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| cfg_valid | input | 1 | Configuration beat offered |
| cfg_ready | output | 1 | Block can take a configuration |
| cfg_src_size | input | 16 | Source size in samples |
| cfg_dst_size | input | 16 | Destination size in samples |
| cfg_div_code | input | 2 | Pre-decimation: 00 none, 01 by 2, 10 by 4 |
| cfg_error | output | 1 | Last configuration taken was illegal |
| step_valid | output | 1 | Step outputs and walk are usable |
| step_master | output | 37 | Master step, 2^21 = unity |
| step_luma | output | 37 | Derived luma step |
| step_chroma | output | 37 | Derived chroma step |
| step_extra | output | 37 | Half step (horizontal) or luma step plus 0x514 (vertical) |
| adv | input | 1 | Advance one output sample |
| src_index | output | 16 | Integer source position |
| phase | output | 21 | Fractional source position |
| phase_sel | output | 4 | Filter phase selector |
| walk_done | output | 1 | All destination samples produced |

## Verification
The advance strobe and the loading of a freshly divided step can land on the same clock edge. The bench provokes this by holding `adv` high from the configuration beat until it sees `step_valid`. At that point the position must read zero, which shows the load won. One cycle later it must read exactly one master step. A second clash comes from a new configuration taken in the middle of a walk. There the bench checks that `step_valid` drops on the next cycle and that the position stops moving.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    DIV_NONE    = 2'b00,
    DIV_HALF    = 2'b01,
    DIV_QUARTER = 2'b10,
    DIV_BAD     = 2'b11
  } div_code_e;

  function automatic int unsigned div_shift(input logic [1:0] code);
    case (code)
      DIV_HALF:    return 1;
      DIV_QUARTER: return 2;
      default:     return 0;
    endcase
  endfunction
endpackage

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int NUM_W = 38,
  parameter int DEN_W = 16,
  parameter int Q_W   = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] n_q;
  logic [DEN_W-1:0] d_q;
  logic [DEN_W-1:0] r_q;
  logic [Q_W-1:0]   q_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial;
  logic             ge;

  assign trial = {r_q, n_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, d_q};
  assign quot  = q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      d_q   <= '0;
      r_q   <= '0;
      q_q   <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        n_q   <= numer;
        d_q   <= denom;
        r_q   <= '0;
        q_q   <= '0;
        cnt_q <= CNT_W'(NUM_W);
        busy  <= 1'b1;
      end else if (busy) begin
        r_q   <= ge ? DEN_W'(trial - {1'b0, d_q}) : trial[DEN_W-1:0];
        q_q   <= {q_q[Q_W-2:0], ge};
        n_q   <= {n_q[NUM_W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: a finished division leaves a remainder below the divisor
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (r_q < d_q));
  // R1: a new start is never issued while a division runs
  assert_no_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/scl_derive.sv
module scl_derive
  import scl_pkg::*;
#(
  parameter int STEP_W   = 37,
  parameter bit VERTICAL = 1'b0,
  parameter int BIAS     = 'h514
) (
  input  logic [STEP_W-1:0] master,
  input  logic [1:0]        code,
  output logic [STEP_W-1:0] luma,
  output logic [STEP_W-1:0] chroma,
  output logic [STEP_W-1:0] extra
);
  assign luma = master >> 2;

  generate
    if (VERTICAL) begin : g_vert
      assign extra  = (master >> 2) + STEP_W'(BIAS);
      assign chroma = (code == DIV_NONE) ? (master >> 2) : (master >> 3);
    end else begin : g_horz
      logic unused_code;
      assign unused_code = ^code;
      assign extra  = master >> 1;
      assign chroma = master >> 2;
    end
  endgenerate
endmodule

// File: rtl/scl_walker.sv
module scl_walker #(
  parameter int SIZE_W = 16,
  parameter int FRAC_W = 21,
  parameter int PSEL_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     cfg_ok,
  input  logic                     adv,
  input  logic [SIZE_W+FRAC_W-1:0] step,
  input  logic [SIZE_W-1:0]        limit,
  output logic [SIZE_W-1:0]        index,
  output logic [FRAC_W-1:0]        frac,
  output logic [PSEL_W-1:0]        psel,
  output logic                     finished
);
  localparam int ACC_W = SIZE_W + FRAC_W;

  logic [ACC_W-1:0]  acc_q;
  logic [SIZE_W-1:0] cnt_q;
  logic              take;

  assign finished = cfg_ok && (cnt_q == limit);
  assign take     = adv && cfg_ok && !finished;
  assign index    = acc_q[ACC_W-1:FRAC_W];
  assign frac     = acc_q[FRAC_W-1:0];
  assign psel     = acc_q[FRAC_W-1 -: PSEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= acc_q + step;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: once all samples are out, the position holds until a reload
  assert_hold_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !load) |=> $stable(acc_q));
  // R9: with no usable step, advances leave the position untouched
  assert_idle_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ok && !load) |=> $stable(acc_q));
endmodule

// File: rtl/scale_step_gen.sv
module scale_step_gen
  import scl_pkg::*;
#(
  parameter int SIZE_W   = 16,
  parameter int FRAC_W   = 21,
  parameter int PSEL_W   = 4,
  parameter bit VERTICAL = 1'b0,
  parameter int BIAS     = 'h514
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_valid,
  output logic                     cfg_ready,
  input  logic [SIZE_W-1:0]        cfg_src_size,
  input  logic [SIZE_W-1:0]        cfg_dst_size,
  input  logic [1:0]               cfg_div_code,
  output logic                     cfg_error,
  output logic                     step_valid,
  output logic [SIZE_W+FRAC_W-1:0] step_master,
  output logic [SIZE_W+FRAC_W-1:0] step_luma,
  output logic [SIZE_W+FRAC_W-1:0] step_chroma,
  output logic [SIZE_W+FRAC_W-1:0] step_extra,
  input  logic                     adv,
  output logic [SIZE_W-1:0]        src_index,
  output logic [FRAC_W-1:0]        phase,
  output logic [PSEL_W-1:0]        phase_sel,
  output logic                     walk_done
);
  localparam int STEP_W = SIZE_W + FRAC_W;
  localparam int NUM_W  = STEP_W + 1;

  logic              accept, legal, div_busy, div_done;
  logic [SIZE_W-1:0] eff;
  logic [NUM_W-1:0]  numer;
  logic [STEP_W-1:0] quot, master_q;
  logic [SIZE_W-1:0] dst_q;
  logic [1:0]        code_q;
  logic              valid_q, err_q;

  assign cfg_ready = !div_busy && !div_done;
  assign accept    = cfg_valid && cfg_ready;
  assign legal     = (cfg_src_size != '0) && (cfg_dst_size != '0) &&
                     (cfg_div_code != DIV_BAD);
  assign eff       = cfg_src_size >> div_shift(cfg_div_code);
  assign numer     = NUM_W'({eff, {FRAC_W{1'b0}}}) + NUM_W'(cfg_dst_size) - NUM_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= '0;
      dst_q    <= '0;
      code_q   <= DIV_NONE;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (accept) begin
        err_q <= !legal;
        if (legal) begin
          valid_q <= 1'b0;
          dst_q   <= cfg_dst_size;
          code_q  <= cfg_div_code;
        end
      end
      if (div_done) begin
        master_q <= quot;
        valid_q  <= 1'b1;
      end
    end
  end

  scl_divider #(.NUM_W(NUM_W), .DEN_W(SIZE_W), .Q_W(STEP_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept && legal),
    .numer (numer),
    .denom (cfg_dst_size),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (quot)
  );

  scl_derive #(.STEP_W(STEP_W), .VERTICAL(VERTICAL), .BIAS(BIAS)) u_derive (
    .master (master_q),
    .code   (code_q),
    .luma   (step_luma),
    .chroma (step_chroma),
    .extra  (step_extra)
  );

  scl_walker #(.SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .PSEL_W(PSEL_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_done),
    .cfg_ok   (valid_q),
    .adv      (adv),
    .step     (master_q),
    .limit    (dst_q),
    .index    (src_index),
    .frac     (phase),
    .psel     (phase_sel),
    .finished (walk_done)
  );

  assign step_master = master_q;
  assign step_valid  = valid_q;
  assign cfg_error   = err_q;

  // R1: a legal beat closes the handshake on the next cycle
  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legal) |=> !cfg_ready);
  // R3: an illegal beat changes no step value and no validity
  assert_illegal_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legal) |=> ($stable(step_master) && $stable(step_valid) && cfg_error));
  // R6: a legal beat withdraws the old step
  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legal) |=> !step_valid);
  // R6: a fresh step starts from position zero
  assert_load_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_valid) |-> (src_index == '0 && phase == '0));
endmodule

// File: tb/scale_step_gen_test.sv
module scale_step_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [15:0] src = '0, dst = '0;
  logic [1:0]  code = '0;
  logic        adv = 1'b0;

  logic        rdy_h, err_h, sv_h, done_h, rdy_v, err_v, sv_v, done_v;
  logic [36:0] m_h, l_h, c_h, x_h, m_v, l_v, c_v, x_v;
  logic [15:0] idx_h, idx_v;
  logic [20:0] ph_h, ph_v;
  logic [3:0]  ps_h, ps_v;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  scale_step_gen #(.VERTICAL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(rdy_h),
    .cfg_src_size(src), .cfg_dst_size(dst), .cfg_div_code(code), .cfg_error(err_h),
    .step_valid(sv_h), .step_master(m_h), .step_luma(l_h), .step_chroma(c_h),
    .step_extra(x_h), .adv(adv), .src_index(idx_h), .phase(ph_h), .phase_sel(ps_h),
    .walk_done(done_h));

  scale_step_gen #(.VERTICAL(1'b1)) uut_v (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(rdy_v),
    .cfg_src_size(src), .cfg_dst_size(dst), .cfg_div_code(code), .cfg_error(err_v),
    .step_valid(sv_v), .step_master(m_v), .step_luma(l_v), .step_chroma(c_v),
    .step_extra(x_v), .adv(adv), .src_index(idx_v), .phase(ph_v), .phase_sel(ps_v),
    .walk_done(done_v));

  // {src, dst, code}
  localparam logic [33:0] VEC [8] = '{
    {16'd360,   16'd720,   2'b00},
    {16'd720,   16'd360,   2'b01},
    {16'd720,   16'd180,   2'b10},
    {16'd704,   16'd704,   2'b00},
    {16'd100,   16'd3,     2'b00},
    {16'd65535, 16'd1,     2'b00},
    {16'd1,     16'd65535, 2'b00},
    {16'd1000,  16'd333,   2'b01}
  };

  function automatic logic [63:0] exp_master(logic [15:0] s, logic [15:0] d, logic [1:0] c);
    logic [63:0] e;
    e = 64'(s) >> ((c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0);
    return ((e << 21) + 64'(d) - 64'd1) / 64'(d);
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(string tag, logic [63:0] act, logic [63:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // offer one beat; adv level is held as given
  task automatic offer(logic [15:0] s, logic [15:0] d, logic [1:0] c);
    @(negedge clk);
    src = s; dst = d; code = c; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_valid();
    while (!sv_h) @(negedge clk);
  endtask

  task automatic pulse_adv(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); adv = 1'b1;
      @(negedge clk); adv = 1'b0;
    end
  endtask

  task automatic chk_pos(string tag, logic [63:0] pos);
    chk_eq({tag, " index h"}, 64'(idx_h), (pos >> 21) & 64'hFFFF);
    chk_eq({tag, " phase h"}, 64'(ph_h), pos & 64'h1FFFFF);
    chk_eq({tag, " phsel h"}, 64'(ps_h), (pos >> 17) & 64'hF);
    chk_eq({tag, " index v"}, 64'(idx_v), (pos >> 21) & 64'hFFFF);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      report();
    end
  end

  initial begin
    logic [63:0] m, m0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk_eq("R1 reset ready", 64'(rdy_h), 1);
    chk_eq("R6 reset valid", 64'(sv_h), 0);
    chk_eq("R3 reset error", 64'(err_h), 0);
    chk_eq("R8 reset done", 64'(done_h), 0);

    // table walk; adv held high through each computation (R9 clash)
    for (int k = 0; k < 8; k++) begin
      logic [15:0] s, d; logic [1:0] c;
      {s, d, c} = VEC[k];
      m = exp_master(s, d, c);
      @(negedge clk); adv = 1'b1;
      offer(s, d, c);
      chk_eq("R6 valid falls", 64'(sv_h), 0);
      chk_eq("R1 ready low", 64'(rdy_h), 0);
      wait_valid();
      chk_pos("R9 load wins", 64'd0);
      @(negedge clk); adv = 1'b0;
      chk_pos("R7 first step", (d >= 1) ? m : 64'd0);
      chk_eq("R2 master h", 64'(m_h), m);
      chk_eq("R2 master v", 64'(m_v), m);
      chk_eq("R4 luma h", 64'(l_h), m >> 2);
      chk_eq("R4 chroma h", 64'(c_h), m >> 2);
      chk_eq("R4 extra h", 64'(x_h), m >> 1);
      chk_eq("R5 luma v", 64'(l_v), m >> 2);
      chk_eq("R5 extra v", 64'(x_v), (m >> 2) + 64'h514);
      chk_eq("R5 chroma v", 64'(c_v), (c == 2'b00) ? (m >> 2) : (m >> 3));
      if (d >= 4) begin
        pulse_adv(3);
        chk_pos("R7 four steps", 4 * m);
      end
    end

    // R3: illegal beats keep the last step
    m0 = 64'(m_h);
    offer(16'd50, 16'd0, 2'b00);
    @(negedge clk);
    chk_eq("R3 zero dst err", 64'(err_h), 1);
    chk_eq("R3 zero dst keep", 64'(m_h), m0);
    chk_eq("R3 zero dst valid", 64'(sv_h), 1);
    offer(16'd0, 16'd50, 2'b00);
    @(negedge clk);
    chk_eq("R3 zero src keep", 64'(m_h), m0);
    offer(16'd50, 16'd50, 2'b11);
    @(negedge clk);
    chk_eq("R3 bad code err", 64'(err_v), 1);
    chk_eq("R3 bad code keep", 64'(m_v), m0);

    // R1: beat offered while busy is ignored; legal beat clears error
    offer(16'd300, 16'd200, 2'b00);
    chk_eq("R3 error cleared", 64'(err_h), 0);
    offer(16'd10, 16'd20, 2'b00);
    wait_valid();
    chk_eq("R1 busy beat ignored", 64'(m_h), exp_master(16'd300, 16'd200, 2'b00));

    // R6: new beat during a walk stops it
    pulse_adv(2);
    offer(16'd7, 16'd5, 2'b10);
    chk_eq("R6 walk interrupted", 64'(sv_h), 0);
    m0 = 64'({idx_h, ph_h});
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
    chk_eq("R9 busy adv ignored", 64'({idx_h, ph_h}), m0);
    wait_valid();

    // R8: end of walk for dst=5
    m = exp_master(16'd7, 16'd5, 2'b10);
    pulse_adv(4);
    chk_eq("R8 not yet done", 64'(done_h), 0);
    pulse_adv(1);
    chk_eq("R8 done high", 64'(done_h), 1);
    chk_pos("R8 five steps", 5 * m);
    pulse_adv(2);
    chk_pos("R8 extra adv ignored", 5 * m);
    chk_eq("R8 done v", 64'(done_v), 1);

    report();
  end
endmodule